// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog driven by a small register port (address, write data, write strobe, combinational read data). A prescaler turns the system clock into ticks of 0.6 s each. The number of clocks per tick is derived from a clock-frequency parameter. While it runs, the counter loses one per tick. Software restarts it from a programmable preset by writing the kick register.

Running out of time once is only a warning. The block raises a first-stage flag and starts a new period from the preset. If the counter runs out again before software has cleared that flag, the block raises the second-stage and boot flags and parks the counter. It then issues a system reset request pulse of fixed length, unless the no-reboot control bit is set. While parked, the counter stays stopped until software either kicks it or writes the control register with the halt bit clear.

The control and status pins are plain level signals. There is no stream data path, so there is no valid/ready handshake and no back-pressure.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset the register reads are as follows. Address 0 (count) and address 1 (preset) read 50. Address 2 (control) reads 0x0801. Address 3 (status A) and address 4 (status B) read 0.
- R2: While running, the count drops by one every CLK_HZ*6/10 clocks. The first decrement after a start or kick comes that many clocks after the write.
- R3: When control bit 11 (halt) is 1, the count does not change.
- R4: A write of any value to address 0 reloads the count from the low 10 bits of the preset. A read of address 0 returns the count in bits 9:0, with the other bits zero.
- R5: A preset write whose bits 9:0 are below 4 is ignored and the old value stays. Otherwise all 16 bits are stored and read back, and only bits 9:0 set the period.
- R6: When the count would step down from 1 to 0 while status A bit 3 is clear, that bit is set and the count reloads from the preset. The count never reads 0.
- R7: When the count would step down from 1 to 0 while status A bit 3 is set, status B bit 1 (second stage) and bit 2 (boot) are both set.
- R8: A second-stage event with control bit 0 (no-reboot) clear drives rst_req high for exactly PULSE_CYC clocks.
- R9: With no-reboot set, a second-stage event leaves rst_req low, and the status flags still update.
- R10: Status bits clear only when a 1 is written to them. Writing 0 leaves them set.
- R11: After a second-stage event the count holds its reloaded value. A kick or a control write with halt clear starts it again.
- R12: If software clears status A or kicks the counter before the next expiry, no second-stage event follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select (0 kick/count, 1 preset, 2 control, 3 status A, 4 status B) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| rst_req | output | 1 | System reset request pulse |

## Verification
The hardest case to reach from the ports is a reset pulse. It needs halt and no-reboot both clear, and then two full timeouts with status A left set in between. Both control bits power up set, so the stimulus has to clear them on purpose. The bench first drives a no-reboot second-stage event to show that the flags update while rst_req stays low. It then clears all flags, writes control as zero, and waits out two periods of a 4-tick preset with a fast prescaler. A behavioural model tracks every clock, so the pulse length and the parked count that follows are compared cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W     = 16;
  localparam int CNT_W     = 10;
  localparam int ADDR_W    = 3;
  localparam int HALT_BIT  = 11;
  localparam int NOREB_BIT = 0;
  localparam int TO1_BIT   = 3;
  localparam int TO2_BIT   = 1;
  localparam int BOOT_BIT  = 2;
  localparam int MIN_PRESET = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_KICK   = 3'd0,
    SEL_PRESET = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_STATA  = 3'd3,
    SEL_STATB  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  generate
    if (DIV == 1) begin : g_passthru
      always_ff @(posedge clk) pre_q <= '0;
      assign tick = run && !restart;
    end else begin : g_count
      always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) pre_q <= '0;
        else if (pre_q == LAST)        pre_q <= '0;
        else                           pre_q <= pre_q + PW'(1);
      end
      assign tick = run && !restart && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int INIT_PRESET = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ev_first,
  input  logic              ev_second,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  preset_q,
  output logic              halt_q,
  output logic              noreb_q,
  output logic              flag1_q,
  output logic              flag2_q,
  output logic              boot_q,
  output logic              kick,
  output logic              unpark
);
  logic wr_preset, wr_ctrl, wr_sta, wr_stb, preset_ok;

  assign kick      = we && (addr == SEL_KICK);
  assign wr_preset = we && (addr == SEL_PRESET);
  assign wr_ctrl   = we && (addr == SEL_CTRL);
  assign wr_sta    = we && (addr == SEL_STATA);
  assign wr_stb    = we && (addr == SEL_STATB);
  assign preset_ok = wdata[CNT_W-1:0] >= CNT_W'(MIN_PRESET);
  assign unpark    = wr_ctrl && !wdata[HALT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= REG_W'(INIT_PRESET);
      halt_q   <= 1'b1;
      noreb_q  <= 1'b1;
    end else begin
      if (wr_preset && preset_ok) preset_q <= wdata;
      if (wr_ctrl) begin
        halt_q  <= wdata[HALT_BIT];
        noreb_q <= wdata[NOREB_BIT];
      end
    end
  end

  // status flags: a setting event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      if (ev_first)                        flag1_q <= 1'b1;
      else if (wr_sta && wdata[TO1_BIT])   flag1_q <= 1'b0;
      if (ev_second)                       flag2_q <= 1'b1;
      else if (wr_stb && wdata[TO2_BIT])   flag2_q <= 1'b0;
      if (ev_second)                       boot_q  <= 1'b1;
      else if (wr_stb && wdata[BOOT_BIT])  boot_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_KICK:   rdata[CNT_W-1:0] = cnt;
      SEL_PRESET: rdata = preset_q;
      SEL_CTRL: begin
        rdata[HALT_BIT]  = halt_q;
        rdata[NOREB_BIT] = noreb_q;
      end
      SEL_STATA:  rdata[TO1_BIT] = flag1_q;
      SEL_STATB: begin
        rdata[TO2_BIT]  = flag2_q;
        rdata[BOOT_BIT] = boot_q;
      end
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int INIT_CNT  = 50,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic             unpark,
  input  logic [CNT_W-1:0] preset,
  input  logic             flag1,
  input  logic             noreb,
  output logic [CNT_W-1:0] cnt_q,
  output logic             parked_q,
  output logic             ev_first,
  output logic             ev_second,
  output logic             rst_req
);
  localparam int PLW = $clog2(PULSE_CYC + 1);

  logic           expire;
  logic [PLW-1:0] pulse_q;

  assign expire    = tick && (cnt_q == CNT_W'(1));
  assign ev_first  = expire && !flag1;
  assign ev_second = expire && flag1;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_CNT);
    else if (kick)   cnt_q <= preset;
    else if (expire) cnt_q <= preset;
    else if (tick)   cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              parked_q <= 1'b0;
    else if (ev_second)      parked_q <= 1'b1;
    else if (kick || unpark) parked_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  pulse_q <= '0;
    else if (ev_second && !noreb) pulse_q <= PLW'(PULSE_CYC);
    else if (pulse_q != '0)      pulse_q <= pulse_q - PLW'(1);
  end

  assign rst_req = (pulse_q != '0);
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_HZ      = 1000000,
  parameter int INIT_PRESET = 50,
  parameter int PULSE_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rst_req
);
  localparam int TICK_DIV = ((CLK_HZ / 10) * 6 > 0) ? (CLK_HZ / 10) * 6 : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] preset_q;
  logic halt_q, noreb_q, flag1_q, flag2_q, boot_q;
  logic kick, unpark, tick, parked_q, ev_first, ev_second, run;

  assign run = !halt_q && !parked_q;

  wdt_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(kick), .tick(tick)
  );

  wdt_regs #(.INIT_PRESET(INIT_PRESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt_q), .ev_first(ev_first), .ev_second(ev_second), .rdata(reg_rdata),
    .preset_q(preset_q), .halt_q(halt_q), .noreb_q(noreb_q), .flag1_q(flag1_q),
    .flag2_q(flag2_q), .boot_q(boot_q), .kick(kick), .unpark(unpark)
  );

  wdt_core #(.INIT_CNT(INIT_PRESET), .PULSE_CYC(PULSE_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .unpark(unpark),
    .preset(preset_q[CNT_W-1:0]), .flag1(flag1_q), .noreb(noreb_q),
    .cnt_q(cnt_q), .parked_q(parked_q), .ev_first(ev_first),
    .ev_second(ev_second), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic              rst_req,
  input logic              halt,
  input logic              noreb,
  input logic              flag1,
  input logic              flag2,
  input logic [CNT_W-1:0]  cnt,
  input logic [REG_W-1:0]  preset
);
  p_halt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(we && addr == SEL_KICK)) |=> $stable(cnt));

  p_kick_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == SEL_KICK) |=> (cnt == $past(preset[CNT_W-1:0])));

  p_preset_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    preset[CNT_W-1:0] >= CNT_W'(MIN_PRESET));

  p_count_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  p_second_after_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag2) |-> $past(flag1));

  p_pulse_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (flag2 && $past(!noreb)));

  p_noreboot_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (noreb && !rst_req) |=> !rst_req);

  p_zero_write_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && we && addr == SEL_STATA && !wdata[TO1_BIT]) |=> flag1);
endmodule

bind two_stage_wdt wdt_checks u_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
  .rst_req(rst_req), .halt(halt_q), .noreb(noreb_q), .flag1(flag1_q),
  .flag2(flag2_q), .cnt(cnt_q), .preset(preset_q)
);

// File: tb/test_two_stage_wdt.sv
module test_two_stage_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int HZ    = 10;
  localparam int DIV   = 6;
  localparam int PULSE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        rst_req;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit saw_rst = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_pre, m_cnt, m_preset, m_halt, m_nor, m_s1, m_sec, m_boot, m_park, m_pulse;
  int t_run, t_kick, t_tick, t_exp, t_second, t_first;

  two_stage_wdt #(.CLK_HZ(HZ), .INIT_PRESET(50), .PULSE_CYC(PULSE)) i_two_stage_wdt (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .rst_req(rst_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int mread(input int a);
    case (a)
      0: return m_cnt;
      1: return m_preset;
      2: return (m_halt << 11) | m_nor;
      3: return m_s1 << 3;
      4: return (m_sec << 1) | (m_boot << 2);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst_req) saw_rst = 1'b1;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 50; m_preset = 50; m_halt = 1; m_nor = 1;
      m_s1 = 0; m_sec = 0; m_boot = 0; m_park = 0; m_pulse = 0;
    end else begin
      t_run    = (m_halt == 0 && m_park == 0) ? 1 : 0;
      t_kick   = (we && addr == 3'd0) ? 1 : 0;
      t_tick   = (t_run == 1 && t_kick == 0 && m_pre == DIV - 1) ? 1 : 0;
      t_exp    = (t_tick == 1 && m_cnt == 1) ? 1 : 0;
      t_second = (t_exp == 1 && m_s1 == 1) ? 1 : 0;
      t_first  = (t_exp == 1 && m_s1 == 0) ? 1 : 0;
      if (t_run == 0 || t_kick == 1 || m_pre == DIV - 1) m_pre = 0;
      else m_pre = m_pre + 1;
      if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (t_second == 1 && m_nor == 0) m_pulse = PULSE;
      if (t_kick == 1 || t_exp == 1) m_cnt = m_preset & 16'h03FF;
      else if (t_tick == 1) m_cnt = m_cnt - 1;
      if (t_kick == 1) m_park = 0;
      if (we && addr == 3'd2 && wdata[11] == 1'b0) m_park = 0;
      if (t_second == 1) m_park = 1;
      if (we && addr == 3'd1 && (wdata & 16'h03FF) >= 4) m_preset = wdata;
      if (we && addr == 3'd2) begin m_halt = wdata[11]; m_nor = wdata[0]; end
      if (we && addr == 3'd3 && wdata[3]) m_s1 = 0;
      if (we && addr == 3'd4 && wdata[1]) m_sec = 0;
      if (we && addr == 3'd4 && wdata[2]) m_boot = 0;
      if (t_first == 1) m_s1 = 1;
      if (t_second == 1) begin m_sec = 1; m_boot = 1; end
    end
  end

  task automatic cyc(input bit w, input int a, input int d);
    @(negedge clk);
    we = w; addr = 3'(a); wdata = 16'(d);
    #1;
    n_run++;
    if (int'(rdata) != mread(a)) begin
      n_fail++;
      $display("FAIL R4 model read addr %0d: actual %h expected %h", a, rdata, mread(a));
    end
    n_run++;
    if (rst_req != (m_pulse > 0)) begin
      n_fail++;
      $display("FAIL R8 model rst_req: actual %0b expected %0b", rst_req, m_pulse > 0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b1, a, d);
  endtask

  task automatic chk(input int a, input int exp, input string tag);
    cyc(1'b0, a, 0);
    n_run++;
    if (int'(rdata) != exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic expect_true(input bit c, input string tag, input int act, input int exp);
    n_run++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    while (!done && cycles < 150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, len, guard;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(0, 50, "R1"); chk(1, 50, "R1"); chk(2, 16'h0801, "R1");
    chk(3, 0, "R1"); chk(4, 0, "R1");

    // R3 halted after reset
    idle(30); chk(0, 50, "R3");

    // R5 preset legality and upper bits
    wr(1, 3);          chk(1, 50, "R5");
    wr(1, 16'hFC05);   chk(1, 16'hFC05, "R5");
    wr(1, 16'h0404);   chk(1, 16'h0404, "R5");

    // R4 kick reloads from low 10 bits
    wr(0, 16'hFFFF);   chk(0, 4, "R4");

    // R2 first decrement DIV clocks after start (no-reboot kept set)
    wr(2, 16'h0001); idle(6); chk(0, 3, "R2");

    // R6 first expiry
    idle(25); chk(3, 16'h0008, "R6");

    // R10 write-0 keeps, write-1 clears
    wr(3, 0);        chk(3, 16'h0008, "R10");
    wr(3, 16'h0008); chk(3, 0, "R10");

    // R12 cleared in time: next expiry is first-stage only
    idle(20); chk(4, 0, "R12"); chk(3, 16'h0008, "R6");

    // R7/R9 second expiry with no-reboot set
    idle(20); chk(4, 16'h0006, "R7"); chk(4, 16'h0006, "R9");
    expect_true(!saw_rst, "R9 rst_req seen", int'(saw_rst), 0);

    // R11 parked
    chk(0, 4, "R11"); idle(20); chk(0, 4, "R11");

    // R8 reset pulse with no-reboot clear
    wr(3, 16'h0008); wr(4, 16'h0006); chk(4, 0, "R10"); chk(3, 0, "R10");
    wr(2, 16'h0000);
    guard = 0;
    while (!rst_req && guard < 200) begin idle(1); guard++; end
    expect_true(rst_req, "R8 pulse start", int'(rst_req), 1);
    len = 0;
    while (rst_req && len < 50) begin idle(1); len++; end
    expect_true(len == PULSE, "R8 pulse length", len, PULSE);
    chk(4, 16'h0006, "R7"); chk(3, 16'h0008, "R7");

    // R11 parked then restarted by kick
    idle(30); chk(0, 4, "R11");
    wr(0, 0); idle(6); chk(0, 3, "R11");

    // R12 regular kicks prevent any expiry
    wr(3, 16'h0008); wr(4, 16'h0006);
    for (int k = 0; k < 10; k++) begin wr(0, 0); idle(9); end
    chk(3, 0, "R12"); chk(4, 0, "R12");

    // R3 halt mid-count
    wr(2, 16'h0800); idle(3);
    cyc(1'b0, 0, 0); v = int'(rdata);
    idle(20); chk(0, v, "R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule